// File: doc/BRIEF.md
# Cascadable Dual-Top Stack Memory

A clocked last-in-first-out word store whose two most recent entries are always visible on separate output ports. The word width and the number of locations are parameters. Each cycle it can push a word, replace the top word, discard the top word, or discard the top two words. It also has a synchronous clear and an overflow flag.

The bottom of the stack is exposed, so identical modules can be chained into a deeper stack. The deepest stored word is driven continuously on `bot_out`. In a chain, that port feeds the `din` of the module below, and the same push command goes to every module. A module pulls replacement words from below through `bot_in_a` and `bot_in_b`. These are normally wired to the top and second ports of the module below, so a two-word discard can refill both vacated deepest locations in a single clock.

Top module: `dual_top_stack`

## Requirements
- R1: `top_q` always shows location 0 and `next_q` always shows location 1.
- R2: On a push, `din` becomes location 0 and every stored word moves one location deeper. The previous deepest word is discarded from this module.
- R3: On a write-top, location 0 takes `din` and all other locations are unchanged.
- R4: On a pop-one, every word moves one location toward the top and the deepest location loads `bot_in_a`.
- R5: On a pop-two, every word moves two locations toward the top. The second-deepest location loads `bot_in_a` and the deepest loads `bot_in_b`.
- R6: `bot_out` always shows the deepest location, so during a push it carries the word being pushed out.
- R7: A push taken while the deepest location is nonzero sets `ovf`. A push with the deepest location at zero clears `ovf`, and so does any pop. Write-top and idle cycles leave `ovf` unchanged.
- R8: When several commands are asserted together, only one is performed. The order of precedence is pop-two, then pop-one, then push, then write-top.
- R9: A synchronous `clear` zeroes every location and `ovf`; clear takes precedence over all commands. With no command asserted, every output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on the rising edge |
| clear | input | 1 | Synchronous clear of all locations and the flag |
| push | input | 1 | Push `din` on top |
| write_top | input | 1 | Replace the top word with `din` |
| pop1 | input | 1 | Discard the top word |
| pop2 | input | 1 | Discard the top two words |
| din | input | W | Word to push or write |
| bot_in_a | input | W | Refill word from below (nearest the bottom edge) |
| bot_in_b | input | W | Second refill word from below, used by pop-two |
| top_q | output | W | Location 0 |
| next_q | output | W | Location 1 |
| bot_out | output | W | Deepest location |
| ovf | output | 1 | Overflow flag |

## Verification
The properties treat `clear` as the only source of a known state. Every clocked check is therefore suspended while it is high, and the stimulus raises it on the first edge before any command. The properties also assume that the refill ports are stable only within the cycle in which a pop samples them. The bench changes `bot_in_a`, `bot_in_b` and `din` only on the falling edge, together with the command that uses them. Commands are expected to be single-cycle levels with no timing relation between them. The bench deliberately asserts several commands at once to exercise the order of precedence.

// File: rtl/dual_top_stack.sv
module dual_top_stack #(
  parameter int W = 8,
  parameter int D = 4
) (
  input  logic         clk,
  input  logic         clear,
  input  logic         push,
  input  logic         write_top,
  input  logic         pop1,
  input  logic         pop2,
  input  logic [W-1:0] din,
  input  logic [W-1:0] bot_in_a,
  input  logic [W-1:0] bot_in_b,
  output logic [W-1:0] top_q,
  output logic [W-1:0] next_q,
  output logic [W-1:0] bot_out,
  output logic         ovf
);

  localparam int LAST = D - 1;

  logic [W-1:0] mem [D];
  logic         deep_busy;

  assign top_q     = mem[0];
  assign next_q    = mem[1];
  assign bot_out   = mem[LAST];
  assign deep_busy = |mem[LAST];

  always_ff @(posedge clk) begin
    if (clear) begin
      for (int i = 0; i < D; i++) mem[i] <= '0;
      ovf <= 1'b0;
    end else if (pop2) begin
      for (int i = 0; i < D - 2; i++) mem[i] <= mem[i+2];
      mem[LAST-1] <= bot_in_a;
      mem[LAST]   <= bot_in_b;
      ovf         <= 1'b0;
    end else if (pop1) begin
      for (int i = 0; i < LAST; i++) mem[i] <= mem[i+1];
      mem[LAST] <= bot_in_a;
      ovf       <= 1'b0;
    end else if (push) begin
      for (int i = 1; i < D; i++) mem[i] <= mem[i-1];
      mem[0] <= din;
      ovf    <= deep_busy;
    end else if (write_top) begin
      mem[0] <= din;
    end
  end

endmodule

// File: rtl/dual_top_stack_chk.sv
module dual_top_stack_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         clear,
  input logic         push,
  input logic         write_top,
  input logic         pop1,
  input logic         pop2,
  input logic [W-1:0] din,
  input logic [W-1:0] bot_in_a,
  input logic [W-1:0] bot_in_b,
  input logic [W-1:0] top_q,
  input logic [W-1:0] next_q,
  input logic [W-1:0] bot_out,
  input logic         ovf
);

  p_push_top_r2: assert property (@(posedge clk) disable iff (clear)
    (push && !pop1 && !pop2) |=> (top_q == $past(din) && next_q == $past(top_q)));

  p_write_top_r3: assert property (@(posedge clk) disable iff (clear)
    (write_top && !push && !pop1 && !pop2) |=>
      (top_q == $past(din) && next_q == $past(next_q) && $stable(bot_out)));

  p_pop1_r4: assert property (@(posedge clk) disable iff (clear)
    (pop1 && !pop2) |=> (top_q == $past(next_q) && bot_out == $past(bot_in_a)));

  p_pop2_r5: assert property (@(posedge clk) disable iff (clear)
    pop2 |=> (bot_out == $past(bot_in_b) && !ovf));

  p_overflow_set_r7: assert property (@(posedge clk) disable iff (clear)
    (push && !pop1 && !pop2 && bot_out != '0) |=> ovf);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (clear)
    (push && !pop1 && !pop2 && bot_out == '0) |=> !ovf);

  p_hold_r9: assert property (@(posedge clk) disable iff (clear)
    (!push && !write_top && !pop1 && !pop2) |=>
      ($stable(top_q) && $stable(next_q) && $stable(bot_out) && $stable(ovf)));

  p_clear_r9: assert property (@(posedge clk)
    clear |=> (top_q == '0 && next_q == '0 && bot_out == '0 && !ovf));

endmodule

bind dual_top_stack dual_top_stack_chk #(.W(W)) u_chk (
  .clk(clk), .clear(clear), .push(push), .write_top(write_top),
  .pop1(pop1), .pop2(pop2), .din(din), .bot_in_a(bot_in_a),
  .bot_in_b(bot_in_b), .top_q(top_q), .next_q(next_q),
  .bot_out(bot_out), .ovf(ovf)
);

// File: tb/dual_top_stack_tb.sv
module dual_top_stack_tb;

  localparam int W = 8;
  localparam int D = 4;
  localparam int NV = 15;

  logic clk = 1'b0;
  logic clear = 1'b1;
  logic push = 1'b0, write_top = 1'b0, pop1 = 1'b0, pop2 = 1'b0;
  logic [W-1:0] din = '0, bot_in_a = '0, bot_in_b = '0;
  logic [W-1:0] top_q, next_q, bot_out;
  logic ovf;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  dual_top_stack #(.W(W), .D(D)) u_dut (
    .clk(clk), .clear(clear), .push(push), .write_top(write_top),
    .pop1(pop1), .pop2(pop2), .din(din), .bot_in_a(bot_in_a),
    .bot_in_b(bot_in_b), .top_q(top_q), .next_q(next_q),
    .bot_out(bot_out), .ovf(ovf)
  );

  // {pop2,pop1,push,write_top}, din, bot_in_a, bot_in_b, exp top, next, bot, ovf
  localparam logic [52:0] VEC [NV] = '{
    {4'b0010, 8'h11, 8'h00, 8'h00, 8'h11, 8'h00, 8'h00, 1'b0},
    {4'b0010, 8'h22, 8'h00, 8'h00, 8'h22, 8'h11, 8'h00, 1'b0},
    {4'b0010, 8'h33, 8'h00, 8'h00, 8'h33, 8'h22, 8'h00, 1'b0},
    {4'b0010, 8'h44, 8'h00, 8'h00, 8'h44, 8'h33, 8'h11, 1'b0},
    {4'b0010, 8'h55, 8'h00, 8'h00, 8'h55, 8'h44, 8'h22, 1'b1},
    {4'b0001, 8'h66, 8'h00, 8'h00, 8'h66, 8'h44, 8'h22, 1'b1},
    {4'b0000, 8'h77, 8'h5A, 8'hA5, 8'h66, 8'h44, 8'h22, 1'b1},
    {4'b0100, 8'h00, 8'hA1, 8'h00, 8'h44, 8'h33, 8'hA1, 1'b0},
    {4'b1000, 8'h00, 8'hB1, 8'hB2, 8'h22, 8'hA1, 8'hB2, 1'b0},
    {4'b1111, 8'h99, 8'hC1, 8'hC2, 8'hB1, 8'hB2, 8'hC2, 1'b0},
    {4'b0110, 8'h12, 8'hD1, 8'h00, 8'hB2, 8'hC1, 8'hD1, 1'b0},
    {4'b0011, 8'h34, 8'h00, 8'h00, 8'h34, 8'hB2, 8'hC2, 1'b1},
    {4'b0010, 8'h56, 8'h00, 8'h00, 8'h56, 8'h34, 8'hC1, 1'b1},
    {4'b0100, 8'h00, 8'h00, 8'h00, 8'h34, 8'hB2, 8'h00, 1'b0},
    {4'b0010, 8'h78, 8'h00, 8'h00, 8'h78, 8'h34, 8'hC1, 1'b0}
  };

  function automatic string req_of(int i);
    case (i)
      0, 1, 2:    return "R2";
      3:          return "R6";
      4, 12, 13:  return "R7";
      14:         return "R7";
      5:          return "R3";
      6:          return "R9";
      7:          return "R4";
      8:          return "R5";
      default:    return "R8";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req, input logic [W-1:0] et,
                           input logic [W-1:0] en, input logic [W-1:0] eb,
                           input logic eo);
    check({"R1/", req}, "top_q", top_q, et);
    check({"R1/", req}, "next_q", next_q, en);
    check({"R6/", req}, "bot_out", bot_out, eb);
    check(req, "ovf", {{(W-1){1'b0}}, ovf}, {{(W-1){1'b0}}, eo});
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(posedge clk);
    @(negedge clk);
    check_all("R9", 8'h00, 8'h00, 8'h00, 1'b0);  // reset state
    clear = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {pop2, pop1, push, write_top} = VEC[i][52:49];
      din      = VEC[i][48:41];
      bot_in_a = VEC[i][40:33];
      bot_in_b = VEC[i][32:25];
      @(posedge clk);
      #1;
      check_all(req_of(i), VEC[i][24:17], VEC[i][16:9], VEC[i][8:1], VEC[i][0]);
    end

    // Overflow set again, then clear overrides a simultaneous push (R9)
    @(negedge clk);
    {pop2, pop1, push, write_top} = 4'b0010;
    din = 8'h01;
    @(posedge clk); #1;
    @(negedge clk);
    {pop2, pop1, push, write_top} = 4'b0010;
    din = 8'h02;
    @(posedge clk); #1;
    check("R7", "ovf after push over nonzero bottom", {7'd0, ovf}, 8'h01);
    @(negedge clk);
    clear = 1'b1;
    din = 8'hEE;
    @(posedge clk); #1;
    check_all("R9", 8'h00, 8'h00, 8'h00, 1'b0);
    @(negedge clk);
    clear = 1'b0;
    {pop2, pop1, push, write_top} = 4'b0000;
    @(posedge clk); #1;
    check_all("R9", 8'h00, 8'h00, 8'h00, 1'b0);

    finish_run();
  end

endmodule